// File: doc/BRIEF.md
# Pixel Word Unpacker and Format Converter

This block sits between a pixel FIFO and a parallel panel data bus. It accepts 32-bit memory words over a valid/ready handshake. For each pixel strobe from the dot-clock timing logic, it sends one pixel onto the panel bus. Each word is unpacked according to three settings: a 2-bit word-length code, a 4-bit byte-packaging mask and a 2-bit bus-width code. A word holds either two 16-bit RGB565 pixels or one 24-bit pixel. A colour-reduction flag maps 24-bit pixels onto an 18-bit panel.

A three-state machine keeps track of the word being unpacked:

- `S_EMPTY` means no word is held.
- `S_FULL` means a word is held and its first (or only) pixel is next.
- `S_HIGH` means the low half of a two-pixel word has been sent and the high half is next.

The transitions are:

- take (`S_EMPTY` to `S_FULL`).
- split (`S_FULL` to `S_HIGH`, when a two-pixel word serves its low half).
- drain (`S_FULL` or `S_HIGH` to `S_EMPTY`, when the last pixel is served and no new word arrives).
- refill (`S_FULL` or `S_HIGH` to `S_FULL`, when the last pixel is served and a new word is accepted in the same cycle).
- flush (any state to `S_EMPTY`).

An unsupported configuration raises an error flag instead of producing pixels. A pixel request with nothing held produces a zero pixel and raises an underflow flag.

Top module: `pix_unpack`

## Requirements
- R1: After reset, `pix_valid`, `underflow` and `pix_out` are 0, and the state is `S_EMPTY`, so `in_ready` is 1 whenever the configuration is legal and `flush` is low.
- R2: With `cfg_wlen`=0, `cfg_pack`=4'hF and `cfg_bus`=0 (16-bit bus), each word yields two pixels. The first is bits 15:0 and the second is bits 31:16, each placed on `pix_out[15:0]` with `pix_out[23:16]`=0. The pixel fields are red 15:11, green 10:5 and blue 4:0. `cfg_df24` has no effect in this mode.
- R3: With `cfg_wlen`=3, `cfg_pack`=4'h7, `cfg_bus`=3 (24-bit bus) and `cfg_df24`=0, each word yields one pixel equal to bits 23:0, and bits 31:24 are ignored.
- R4: With `cfg_wlen`=3, `cfg_pack`=4'h7, `cfg_bus`=2 (18-bit bus) and `cfg_df24`=1, each word yields one pixel. It has red bits 23:18 on `pix_out[17:12]`, green bits 15:10 on `pix_out[11:6]` and blue bits 7:2 on `pix_out[5:0]`, with `pix_out[23:18]`=0.
- R5: Any other combination, including bus code 1 (8-bit), drives `cfg_err` high. While `cfg_err` is high, `in_ready` is 0 and a pixel request produces no `pix_valid`.
- R6: A pixel request in `S_EMPTY` gives `pix_valid`=1, `underflow`=1 and `pix_out`=0 one cycle later.
- R7: Every served request shows its pixel on `pix_out` with `pix_valid`=1 exactly one cycle after the request cycle. `in_ready` is 1 in the cycle that requests the last pixel of the held word, so a new word can be loaded with no gap.
- R8: `flush` discards the held word and clears the outputs on the next cycle. `in_ready` is 0 and a request is ignored during the flush cycle, and the next request after it underflows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Discard held word and clear outputs |
| cfg_wlen | input | 2 | Word-length code (0: 16-bit, 3: 24-bit pixels) |
| cfg_bus | input | 2 | Bus width code (0: 16, 1: 8, 2: 18, 3: 24 bits) |
| cfg_pack | input | 4 | Byte-packaging mask, one bit per valid byte |
| cfg_df24 | input | 1 | Reduce 24-bit pixels to 6 bits per component |
| in_data | input | 32 | Word from the pixel FIFO |
| in_valid | input | 1 | Word available |
| in_ready | output | 1 | Word accepted when high together with in_valid |
| pix_req | input | 1 | Dot-clock pixel strobe |
| pix_out | output | 24 | Panel pixel data |
| pix_valid | output | 1 | pix_out holds a pixel for the previous request |
| underflow | output | 1 | The previous request found no word |
| cfg_err | output | 1 | Configuration combination unsupported |

## Verification
Pixel results are registered, so each one is due one clock edge after the edge that samples the request. The bench raises `pix_req` just after a falling edge and reads `pix_out`, `pix_valid` and `underflow` at the next falling edge. `in_ready` and `cfg_err` are combinational, so they are read shortly after the inputs change, before the next rising edge. The flush and back-to-back scenarios check both the cycle of the stimulus and the cycle that follows it.

// File: rtl/pix_pkg.sv
package pix_pkg;
    localparam int WORD_W = 32;
    localparam int PIX_W  = 24;

    typedef enum logic [1:0] {
        S_EMPTY = 2'd0,
        S_FULL  = 2'd1,
        S_HIGH  = 2'd2
    } unpack_state_t;

    typedef enum logic [1:0] {
        FMT_565 = 2'd0,
        FMT_888 = 2'd1,
        FMT_666 = 2'd2,
        FMT_BAD = 2'd3
    } pix_fmt_t;

    localparam logic [1:0] WLEN_16 = 2'd0;
    localparam logic [1:0] WLEN_24 = 2'd3;
    localparam logic [1:0] BUS_16  = 2'd0;
    localparam logic [1:0] BUS_18  = 2'd2;
    localparam logic [1:0] BUS_24  = 2'd3;
    localparam logic [3:0] PACK_ALL = 4'hF;
    localparam logic [3:0] PACK_LO3 = 4'h7;
endpackage

// File: rtl/pix_cfg_decode.sv
module pix_cfg_decode
    import pix_pkg::*;
(
    input  logic [1:0] wlen,
    input  logic [1:0] bus,
    input  logic [3:0] pack,
    input  logic       df24,
    output pix_fmt_t   fmt,
    output logic       two_per_word,
    output logic       bad
);
    always_comb begin
        fmt = FMT_BAD;
        if (wlen == WLEN_16 && pack == PACK_ALL && bus == BUS_16)
            fmt = FMT_565;
        else if (wlen == WLEN_24 && pack == PACK_LO3) begin
            if (bus == BUS_24 && !df24)
                fmt = FMT_888;
            else if (bus == BUS_18 && df24)
                fmt = FMT_666;
        end
        two_per_word = (fmt == FMT_565);
        bad          = (fmt == FMT_BAD);
    end
endmodule

// File: rtl/pix_format.sv
module pix_format
    import pix_pkg::*;
#(
    parameter int WW = WORD_W,
    parameter int PW = PIX_W
) (
    input  logic [WW-1:0] word,
    input  logic          sel_hi,
    input  pix_fmt_t      fmt,
    output logic [PW-1:0] pix
);
    localparam int HALF = WW / 2;
    localparam int COMP = PW / 3;
    localparam int RED6 = COMP - 2;

    logic [HALF-1:0] half;
    logic [RED6-1:0] r6, g6, b6;

    always_comb begin
        half = sel_hi ? word[WW-1:HALF] : word[HALF-1:0];
        r6   = word[3*COMP-1 -: RED6];
        g6   = word[2*COMP-1 -: RED6];
        b6   = word[COMP-1   -: RED6];
        pix  = '0;
        unique case (fmt)
            FMT_565: pix[HALF-1:0]   = half;
            FMT_888: pix             = word[PW-1:0];
            FMT_666: pix[3*RED6-1:0] = {r6, g6, b6};
            FMT_BAD: pix             = '0;
        endcase
    end
endmodule

// File: rtl/pix_unpack.sv
module pix_unpack
    import pix_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic [1:0]        cfg_wlen,
    input  logic [1:0]        cfg_bus,
    input  logic [3:0]        cfg_pack,
    input  logic              cfg_df24,
    input  logic [WORD_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              pix_req,
    output logic [PIX_W-1:0]  pix_out,
    output logic              pix_valid,
    output logic              underflow,
    output logic              cfg_err
);
    unpack_state_t     state, state_nxt;
    pix_fmt_t          fmt;
    logic              two_per;
    logic [WORD_W-1:0] word_q;
    logic [PIX_W-1:0]  fmt_pix;
    logic              serve, take, last_pix;

    pix_cfg_decode u_dec (
        .wlen(cfg_wlen), .bus(cfg_bus), .pack(cfg_pack), .df24(cfg_df24),
        .fmt(fmt), .two_per_word(two_per), .bad(cfg_err)
    );

    pix_format u_fmt (
        .word(word_q), .sel_hi(state == S_HIGH), .fmt(fmt), .pix(fmt_pix)
    );

    always_comb begin
        serve    = pix_req && !cfg_err && !flush;
        last_pix = (state == S_HIGH) || (state == S_FULL && !two_per);
        in_ready = !flush && !cfg_err &&
                   (state == S_EMPTY || (serve && last_pix));
        take     = in_valid && in_ready;
        state_nxt = state;
        unique case (state)
            S_EMPTY: if (take) state_nxt = S_FULL;
            S_FULL: begin
                if (serve) begin
                    if (two_per)   state_nxt = S_HIGH;
                    else if (take) state_nxt = S_FULL;
                    else           state_nxt = S_EMPTY;
                end
            end
            S_HIGH: if (serve) state_nxt = take ? S_FULL : S_EMPTY;
            default: state_nxt = S_EMPTY;
        endcase
        if (flush) state_nxt = S_EMPTY;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= S_EMPTY;
            word_q <= '0;
        end else begin
            state <= state_nxt;
            if (take) word_q <= in_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_out   <= '0;
            pix_valid <= 1'b0;
            underflow <= 1'b0;
        end else begin
            pix_valid <= serve;
            underflow <= serve && (state == S_EMPTY);
            pix_out   <= (serve && state != S_EMPTY) ? fmt_pix : '0;
        end
    end

    // R5: an illegal configuration never accepts words
    p_err_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> !in_ready);
    // R5: a request under an illegal configuration produces no pixel
    p_err_no_pixel_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_err && pix_req) |=> !pix_valid);
    // R6: an underflow pixel is zero and marked valid
    p_underflow_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |-> (pix_valid && pix_out == '0));
    // R7: a pixel only follows a request one cycle earlier
    p_valid_after_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pix_valid) |-> $past(pix_req));
    // R8: the cycle after a flush carries no pixel
    p_flush_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!pix_valid && !underflow));
endmodule

// File: tb/pix_unpack_tb_top.sv
module pix_unpack_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic [1:0]  cfg_wlen = 2'd0;
    logic [1:0]  cfg_bus = 2'd0;
    logic [3:0]  cfg_pack = 4'hF;
    logic        cfg_df24 = 1'b0;
    logic [31:0] in_data = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic        pix_req = 1'b0;
    logic [23:0] pix_out;
    logic        pix_valid, underflow, cfg_err;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    pix_unpack dut_i (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .cfg_wlen(cfg_wlen), .cfg_bus(cfg_bus), .cfg_pack(cfg_pack),
        .cfg_df24(cfg_df24), .in_data(in_data), .in_valid(in_valid),
        .in_ready(in_ready), .pix_req(pix_req), .pix_out(pix_out),
        .pix_valid(pix_valid), .underflow(underflow), .cfg_err(cfg_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] to666(input logic [31:0] w);
        return {6'b0, w[23:18], w[15:10], w[7:2]};
    endfunction

    task automatic set_cfg(input logic [1:0] wl, input logic [1:0] bw,
                           input logic [3:0] pk, input logic d24);
        cfg_wlen = wl; cfg_bus = bw; cfg_pack = pk; cfg_df24 = d24;
    endtask

    task automatic push(input logic [31:0] w);
        in_data = w; in_valid = 1'b1;
        @(posedge clk); @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic request(output logic [23:0] px, output logic v, output logic uf);
        pix_req = 1'b1;
        @(posedge clk); @(negedge clk);
        pix_req = 1'b0;
        px = pix_out; v = pix_valid; uf = underflow;
    endtask

    task automatic t_reset;
        chk("R1 pix_valid", {31'b0, pix_valid}, 32'd0);
        chk("R1 underflow", {31'b0, underflow}, 32'd0);
        chk("R1 pix_out", {8'b0, pix_out}, 32'd0);
        chk("R1 in_ready", {31'b0, in_ready}, 32'd1);
    endtask

    task automatic t_rgb565;
        logic [23:0] px; logic v, uf;
        set_cfg(2'd0, 2'd0, 4'hF, 1'b1);
        push(32'hBEEF_1234);
        request(px, v, uf);
        chk("R2 low half first", {8'b0, px}, 32'h0000_1234);
        chk("R2 valid", {31'b0, v}, 32'd1);
        request(px, v, uf);
        chk("R2 high half second", {8'b0, px}, 32'h0000_BEEF);
        chk("R2 no underflow", {31'b0, uf}, 32'd0);
    endtask

    task automatic t_rgb888;
        logic [23:0] px; logic v, uf;
        set_cfg(2'd3, 2'd3, 4'h7, 1'b0);
        push(32'hAA12_3456);
        request(px, v, uf);
        chk("R3 top byte ignored", {8'b0, px}, 32'h0012_3456);
        request(px, v, uf);
        chk("R3 one pixel per word", {31'b0, uf}, 32'd1);
    endtask

    task automatic t_rgb666;
        logic [23:0] px; logic v, uf;
        set_cfg(2'd3, 2'd2, 4'h7, 1'b1);
        push(32'hFFFC_8043);
        request(px, v, uf);
        chk("R4 reduced pixel", {8'b0, px}, {8'b0, to666(32'hFFFC_8043)});
        push(32'h0003_7FFF);
        request(px, v, uf);
        chk("R4 reduced pixel 2", {8'b0, px}, {8'b0, to666(32'h0003_7FFF)});
    endtask

    task automatic t_bad_cfg;
        logic [23:0] px; logic v, uf;
        set_cfg(2'd3, 2'd2, 4'h7, 1'b0);
        #1;
        chk("R5 err 18-bit no df24", {31'b0, cfg_err}, 32'd1);
        chk("R5 ready low", {31'b0, in_ready}, 32'd0);
        request(px, v, uf);
        chk("R5 no pixel", {31'b0, v}, 32'd0);
        set_cfg(2'd0, 2'd1, 4'hF, 1'b0);
        #1;
        chk("R5 err 8-bit bus", {31'b0, cfg_err}, 32'd1);
        set_cfg(2'd0, 2'd0, 4'h7, 1'b0);
        #1;
        chk("R5 err wrong mask", {31'b0, cfg_err}, 32'd1);
        set_cfg(2'd3, 2'd3, 4'h7, 1'b0);
        #1;
        chk("R5 legal clears err", {31'b0, cfg_err}, 32'd0);
    endtask

    task automatic t_underflow;
        logic [23:0] px; logic v, uf;
        set_cfg(2'd3, 2'd3, 4'h7, 1'b0);
        request(px, v, uf);
        chk("R6 underflow flag", {31'b0, uf}, 32'd1);
        chk("R6 valid", {31'b0, v}, 32'd1);
        chk("R6 zero pixel", {8'b0, px}, 32'd0);
    endtask

    task automatic t_back_to_back;
        logic [23:0] px; logic v, uf;
        set_cfg(2'd3, 2'd3, 4'h7, 1'b0);
        push(32'h0011_2233);
        in_data = 32'h0044_5566; in_valid = 1'b1; pix_req = 1'b1;
        #1;
        chk("R7 ready on last pixel", {31'b0, in_ready}, 32'd1);
        @(posedge clk); @(negedge clk);
        in_valid = 1'b0; pix_req = 1'b0;
        chk("R7 first pixel next cycle", {8'b0, pix_out}, 32'h0011_2233);
        chk("R7 first valid", {31'b0, pix_valid}, 32'd1);
        @(posedge clk); @(negedge clk);
        chk("R7 valid drops without request", {31'b0, pix_valid}, 32'd0);
        request(px, v, uf);
        chk("R7 refilled pixel", {8'b0, px}, 32'h0044_5566);
        chk("R7 no underflow", {31'b0, uf}, 32'd0);
    endtask

    task automatic t_flush;
        logic [23:0] px; logic v, uf;
        set_cfg(2'd0, 2'd0, 4'hF, 1'b0);
        push(32'h5555_AAAA);
        flush = 1'b1; pix_req = 1'b1;
        #1;
        chk("R8 ready low in flush", {31'b0, in_ready}, 32'd0);
        @(posedge clk); @(negedge clk);
        flush = 1'b0; pix_req = 1'b0;
        chk("R8 no pixel after flush", {31'b0, pix_valid}, 32'd0);
        request(px, v, uf);
        chk("R8 held word discarded", {31'b0, uf}, 32'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_rgb565();
        t_rgb888();
        t_rgb666();
        t_bad_cfg();
        t_underflow();
        t_back_to_back();
        t_flush();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1000000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule